// File: doc/BRIEF.md
# Leaf Block Tile Extractor

This block takes one fixed-size leaf block of a compressed texture and pulls out the bytes of a single tile for a downstream tile decoder. The leaf is loaded into a local byte store through a simple write port, one byte per cycle. A request then names the leaf kind (packed or raw), the number of table entries in a packed leaf, and the index of the wanted tile.

A packed leaf starts with a byte table that has one start offset per tile, followed by one closing entry. Tile data follows the table. The length of a tile is the difference between its own entry and the next one, and a zero length marks a void tile. A raw leaf has no table and holds four 64-byte tiles back to back.

The result is a 64-byte tile image with zero padding, a 7-bit length, a void flag and an error flag. It is registered and offered on a valid/ready output. Malformed or out-of-range requests set the error flag and carry no data.

Top module: `leafx_top`

## Requirements
- R1: After reset `out_valid` is 0 and `req_ready` is 1.
- R2: A byte written with `wr_en` high at `wr_addr` is what later requests read at that address, and a rewrite replaces it.
- R3: For a raw leaf (`req_packed`=0) and index i in 0..3, the result carries bytes i*64 .. i*64+63 with `out_len`=64. Result byte k is at `out_tile[8k+7:8k]`.
- R4: For a raw leaf, an index of 4 or more gives `out_err`=1, `out_len`=0 and an all-zero tile.
- R5: For a packed leaf with N=`req_count` entries, table entry j is the byte at address j and the closing entry is at address N. Tile i covers the bytes from entry[i] up to entry[i+1]-1, and `out_len` = entry[i+1] - entry[i].
- R6: Equal adjacent entries give `out_void`=1, `out_len`=0, `out_err`=0 and an all-zero tile.
- R7: For a packed leaf, an index at or above N, including any index when N=0, gives `out_err`=1.
- R8: For a packed leaf, entry[i+1] < entry[i] gives `out_err`=1.
- R9: For a packed leaf, a length above 64 gives `out_err`=1, and a length of exactly 64 is accepted.
- R10: Every tile byte at a position at or beyond `out_len` is zero.
- R11: `req_ready` = !`out_valid` or `out_ready`. A request accepted at a clock edge has its result valid right after that edge.
- R12: While `out_valid`=1 and `out_ready`=0, the outputs do not change and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one byte into the leaf store |
| wr_addr | input | 8 | Byte address within the leaf |
| wr_data | input | 8 | Byte to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_packed | input | 1 | 1 = leaf with offset table, 0 = raw leaf |
| req_count | input | 8 | Number of table entries in a packed leaf |
| req_index | input | 8 | Tile index within the leaf |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_tile | output | 512 | Tile bytes, zero padded |
| out_len | output | 7 | Tile length in bytes, 0..64 |
| out_void | output | 1 | Tile is void (zero length) |
| out_err | output | 1 | Request was malformed or out of range |

## Verification
The bench targets the edges of the table walk. These are a void entry next to occupied ones, a tile of exactly 64 bytes next to one of 65, a descending entry pair, an index equal to the entry count, and a raw index of 4. A design with an off-by-one in the table lookup would return the neighbouring tile's bytes or length. A design with a wrong bound would pass a 65-byte tile or reject a 64-byte one. A design without masking would leak leaf bytes past the tile end into the padding. A stalled consumer with a second request waiting tests whether a design overwrites a held result or drops the waiting request.

// File: rtl/leafx_pkg.sv
package leafx_pkg;
  localparam int LEAF_BYTES_DEF = 256;
  localparam int TILE_BYTES_DEF = 64;

  typedef enum logic {
    LEAF_RAW    = 1'b0,
    LEAF_PACKED = 1'b1
  } leaf_kind_e;
endpackage

// File: rtl/leafx_store.sv
module leafx_store #(
  parameter int LEAF_BYTES = leafx_pkg::LEAF_BYTES_DEF,
  localparam int AW = $clog2(LEAF_BYTES)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [7:0]              wr_data,
  output logic [LEAF_BYTES*8-1:0] flat
);
  logic [7:0] mem [LEAF_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar b = 0; b < LEAF_BYTES; b++) begin : g_view
    assign flat[b*8 +: 8] = mem[b];
  end
endmodule

// File: rtl/leafx_span.sv
module leafx_span #(
  parameter int LEAF_BYTES = leafx_pkg::LEAF_BYTES_DEF,
  parameter int TILE_BYTES = leafx_pkg::TILE_BYTES_DEF,
  localparam int AW = $clog2(LEAF_BYTES),
  localparam int LW = $clog2(TILE_BYTES + 1),
  localparam int TW = $clog2(TILE_BYTES),
  localparam int SW = AW - TW,
  localparam int RAW_SLOTS = LEAF_BYTES / TILE_BYTES
) (
  input  logic [LEAF_BYTES*8-1:0] flat,
  input  leafx_pkg::leaf_kind_e   kind,
  input  logic [AW-1:0]           count,
  input  logic [AW-1:0]           index,
  output logic [AW-1:0]           start,
  output logic [LW-1:0]           len,
  output logic                    vacant,
  output logic                    err
);
  logic [AW-1:0] nxt;
  logic [7:0]    off_lo, off_hi;
  logic [AW:0]   diff;
  logic          p_err, r_err;

  assign nxt    = index + AW'(1);
  assign off_lo = flat[{index, 3'b000} +: 8];
  assign off_hi = flat[{nxt, 3'b000} +: 8];
  assign diff   = {1'b0, off_hi[AW-1:0]} - {1'b0, off_lo[AW-1:0]};

  // packed leaf: index past table, descending pair, or over-long tile
  assign p_err = (index >= count) || diff[AW] || (diff > (AW+1)'(TILE_BYTES));
  // raw leaf: only the fixed slots exist
  assign r_err = ({1'b0, index} >= (AW+1)'(RAW_SLOTS));

  always_comb begin
    if (kind == leafx_pkg::LEAF_PACKED) begin
      start  = off_lo[AW-1:0];
      len    = p_err ? '0 : LW'(diff);
      err    = p_err;
      vacant = !p_err && (diff == '0);
    end else begin
      start  = {index[SW-1:0], {TW{1'b0}}};
      len    = r_err ? '0 : LW'(TILE_BYTES);
      err    = r_err;
      vacant = 1'b0;
    end
  end
endmodule

// File: rtl/leafx_gather.sv
module leafx_gather #(
  parameter int LEAF_BYTES = leafx_pkg::LEAF_BYTES_DEF,
  parameter int TILE_BYTES = leafx_pkg::TILE_BYTES_DEF,
  localparam int AW = $clog2(LEAF_BYTES),
  localparam int LW = $clog2(TILE_BYTES + 1)
) (
  input  logic [LEAF_BYTES*8-1:0] flat,
  input  logic [AW-1:0]           start,
  input  logic [LW-1:0]           len,
  output logic [TILE_BYTES*8-1:0] tile
);
  for (genvar k = 0; k < TILE_BYTES; k++) begin : g_byte
    logic [AW-1:0] addr;
    assign addr = start + AW'(k);
    assign tile[k*8 +: 8] = (LW'(k) < len) ? flat[{addr, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/leafx_top.sv
module leafx_top #(
  parameter int LEAF_BYTES = leafx_pkg::LEAF_BYTES_DEF,
  parameter int TILE_BYTES = leafx_pkg::TILE_BYTES_DEF,
  localparam int AW = $clog2(LEAF_BYTES),
  localparam int LW = $clog2(TILE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_packed,
  input  logic [AW-1:0]           req_count,
  input  logic [AW-1:0]           req_index,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [TILE_BYTES*8-1:0] out_tile,
  output logic [LW-1:0]           out_len,
  output logic                    out_void,
  output logic                    out_err
);
  logic [LEAF_BYTES*8-1:0] flat;
  logic [AW-1:0]           sp_start;
  logic [LW-1:0]           sp_len;
  logic                    sp_void, sp_err;
  logic [TILE_BYTES*8-1:0] g_tile;
  logic                    accept;
  leafx_pkg::leaf_kind_e   kind;

  assign kind      = leafx_pkg::leaf_kind_e'(req_packed);
  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  leafx_store #(.LEAF_BYTES(LEAF_BYTES)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .flat(flat)
  );

  leafx_span #(.LEAF_BYTES(LEAF_BYTES), .TILE_BYTES(TILE_BYTES)) u_span (
    .flat(flat), .kind(kind), .count(req_count), .index(req_index),
    .start(sp_start), .len(sp_len), .vacant(sp_void), .err(sp_err)
  );

  leafx_gather #(.LEAF_BYTES(LEAF_BYTES), .TILE_BYTES(TILE_BYTES)) u_gather (
    .flat(flat), .start(sp_start), .len(sp_len), .tile(g_tile)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tile  <= '0;
      out_len   <= '0;
      out_void  <= 1'b0;
      out_err   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_tile  <= g_tile;
      out_len   <= sp_len;
      out_void  <= sp_void;
      out_err   <= sp_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/leafx_check.sv
module leafx_check #(
  parameter int LEAF_BYTES = leafx_pkg::LEAF_BYTES_DEF,
  parameter int TILE_BYTES = leafx_pkg::TILE_BYTES_DEF,
  localparam int AW = $clog2(LEAF_BYTES),
  localparam int LW = $clog2(TILE_BYTES + 1),
  localparam int RAW_SLOTS = LEAF_BYTES / TILE_BYTES
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_packed,
  input logic [AW-1:0]           req_index,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [TILE_BYTES*8-1:0] out_tile,
  input logic [LW-1:0]           out_len,
  input logic                    out_void,
  input logic                    out_err
);
  a_r11_accept_valid: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> out_valid);

  a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tile) && $stable(out_len)
                                   && $stable(out_void) && $stable(out_err)));

  a_r12_blocked: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !req_ready);

  a_r4_raw_range: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_packed && ({1'b0, req_index} >= (AW+1)'(RAW_SLOTS)))
      |=> out_err);

  a_r9_len_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len <= LW'(TILE_BYTES)));

  a_r6_void_shape: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_void) |-> (out_len == '0 && !out_err && out_tile == '0));

  a_r7_err_shape: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_len == '0 && out_tile == '0 && !out_void));

  a_r10_zero_pad: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_tile >> {out_len, 3'b000}) == '0));
endmodule

bind leafx_top leafx_check #(.LEAF_BYTES(LEAF_BYTES), .TILE_BYTES(TILE_BYTES)) u_check (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_packed(req_packed), .req_index(req_index), .out_valid(out_valid),
  .out_ready(out_ready), .out_tile(out_tile), .out_len(out_len),
  .out_void(out_void), .out_err(out_err)
);

// File: tb/leafx_top_test.sv
module leafx_top_test;
  logic         clk = 0;
  logic         rst = 1;
  logic         wr_en = 0;
  logic [7:0]   wr_addr = 0, wr_data = 0;
  logic         req_valid = 0, req_packed = 0;
  logic [7:0]   req_count = 0, req_index = 0;
  logic         req_ready, out_valid;
  logic         out_ready = 1;
  logic [511:0] out_tile;
  logic [6:0]   out_len;
  logic         out_void, out_err;

  int errors = 0;
  int checks = 0;

  logic [7:0]   model [256];
  logic [511:0] q_tile [$];
  logic [6:0]   q_len  [$];
  logic         q_void [$];
  logic         q_err  [$];
  string        q_tag  [$];

  always #4 clk = ~clk;

  leafx_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_packed(req_packed),
    .req_count(req_count), .req_index(req_index), .out_valid(out_valid),
    .out_ready(out_ready), .out_tile(out_tile), .out_len(out_len),
    .out_void(out_void), .out_err(out_err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 8'(a); wr_data = 8'(d);
    model[a] = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  // expected result computed from the requirement text
  task automatic predict(input bit pk, input int cnt, input int idx, input string tag);
    logic [511:0] t = '0;
    int len = 0;
    int base = 0;
    bit e = 0;
    if (!pk) begin
      if (idx >= 4) e = 1;
      else begin base = idx * 64; len = 64; end
    end else begin
      if (idx >= cnt) e = 1;
      else begin
        base = int'(model[idx]);
        len  = int'(model[idx+1]) - base;
        if (len < 0 || len > 64) e = 1;
      end
    end
    if (e) len = 0;
    for (int k = 0; k < len; k++) t[k*8 +: 8] = model[(base + k) % 256];
    q_tile.push_back(t);
    q_len.push_back(7'(len));
    q_void.push_back(!e && len == 0);
    q_err.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic send(input bit pk, input int cnt, input int idx, input string tag);
    predict(pk, cnt, idx, tag);
    @(negedge clk);
    req_valid = 1; req_packed = pk; req_count = 8'(cnt); req_index = 8'(idx);
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_valid = 0;
    check(out_valid === 1'b1, "R11", "valid after accept", 512'(out_valid), 512'(1));
  endtask

  // monitor: compare at each output handshake, watch holds
  logic         held = 0;
  logic [511:0] h_tile;
  logic [6:0]   h_len;
  logic         h_err, h_void;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) begin
        check(out_valid === 1'b1 && out_tile === h_tile && out_len === h_len
              && out_err === h_err && out_void === h_void,
              "R12", "held output changed", {out_len, out_tile[63:0]}, {h_len, h_tile[63:0]});
      end
      held = out_valid && !out_ready;
      if (held) begin
        h_tile = out_tile; h_len = out_len; h_err = out_err; h_void = out_void;
        check(req_ready === 1'b0, "R12", "ready while blocked", 512'(req_ready), 512'(0));
      end
      if (out_valid && out_ready) begin
        if (q_tag.size() == 0) begin
          check(0, "R11", "unexpected output", 512'(1), 512'(0));
        end else begin
          automatic string tg = q_tag.pop_front();
          automatic logic [511:0] et = q_tile.pop_front();
          automatic logic [6:0] el = q_len.pop_front();
          automatic logic ev = q_void.pop_front();
          automatic logic ee = q_err.pop_front();
          check(out_len === el, tg, "length", 512'(out_len), 512'(el));
          check(out_tile === et, tg, "tile bytes (R10 padding)", out_tile, et);
          check(out_void === ev, tg, "void flag", 512'(out_void), 512'(ev));
          check(out_err === ee, tg, "error flag", 512'(out_err), 512'(ee));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "valid after reset", 512'(out_valid), 512'(0));
    check(req_ready === 1'b1, "R1", "ready after reset", 512'(req_ready), 512'(1));

    for (int a = 0; a < 256; a++) wr(a, a ^ 8'h5A);

    // R3 raw slots
    for (int i = 0; i < 4; i++) send(0, 0, i, "R3");
    // R4 raw out of range
    send(0, 0, 4, "R4");
    send(0, 0, 255, "R4");
    // R2 rewrite then reread
    wr(130, 8'hC3);
    wr(191, 8'h11);
    send(0, 0, 2, "R2");

    // packed table: entries 7,7,20,20,84,80 ; closing 200
    wr(0, 7); wr(1, 7); wr(2, 20); wr(3, 20); wr(4, 84); wr(5, 80); wr(6, 200);
    send(1, 6, 0, "R6");
    send(1, 6, 1, "R5");
    send(1, 6, 2, "R6");
    send(1, 6, 3, "R9");  // exactly 64
    send(1, 6, 4, "R8");  // 84 -> 80
    send(1, 6, 5, "R9");  // 120
    send(1, 6, 6, "R7");
    send(1, 6, 200, "R7");
    send(1, 0, 0, "R7");
    // other data pattern and 65-byte span
    for (int a = 7; a < 20; a++) wr(a, 8'hF0 - a);
    send(1, 6, 1, "R5");
    wr(4, 85);
    send(1, 6, 3, "R9");  // 65
    // shorter table: closing entry at address 2
    send(1, 2, 1, "R5");

    // R12 backpressure with a waiting request
    out_ready = 0;
    fork
      begin
        send(1, 6, 1, "R12");
        send(0, 0, 1, "R12");
      end
      begin
        repeat (6) @(negedge clk);
        out_ready = 1;
      end
    join

    repeat (4) @(negedge clk);
    check(q_tag.size() == 0, "R11", "results outstanding", 512'(q_tag.size()), 512'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule